// File: doc/BRIEF.md
# Four-Wire Display Serial Master with Register Read

This block drives a small display controller over a serial link that has a separate data/command line. A transaction starts with one command byte sent with the line held low. For a write, a burst of parameter or pixel bytes follows with the line held high. For a read, the block clocks in the requested number of bytes and presents each one on a byte-wide output with a one-cycle valid strobe. The link uses mode 0: the clock idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. Bits go most significant first.

Each phase has its own serial clock rate, and all rates come from parameters. Command and parameter bytes run at no more than 10 MHz. Pixel bytes that follow the memory-write command (0x2C) run at the full configured maximum. Reads run at the lower of 2 MHz and half of that maximum. Two read commands, display identity (0x04) and display status (0x09), answer with one dummy bit first. For these the block receives one extra byte and shifts the result left by one bit to drop the dummy bit. Chip select stays low for the whole transaction and goes high between transactions.

A host requests a transaction by pulsing `start` with a command and a length. During a write it supplies each data byte on `tx_byte` and advances to the next byte when `tx_take` pulses. It waits for the `done` pulse before the next request.

Top module: `dbi_spi_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, dc is 0, busy is 0 and done is 0.
- R2: The command byte is sent first with dc = 0 and cs_n = 0. Bits go MSB first in mode 0, and mosi is stable while sclk is high.
- R3: For a write, each of `len` data bytes is taken from tx_byte and sent with dc = 1 for all of its bits, in order. tx_take pulses exactly once per data byte.
- R4: The command byte and the data bytes of any command other than 0x2C have an sclk high time of 5 clock cycles (10 MHz at the default 100 MHz clock and 25 MHz maximum).
- R5: Data bytes after command 0x2C have an sclk high time of 2 clock cycles (full rate).
- R6: The read commands are 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 and 0xA8. After the command byte, a read clocks `len` bytes with an sclk high time of 25 clock cycles (2 MHz) while mosi = 0 and dc = 0. Each received byte, MSB first, comes out on rd_data with one rd_valid pulse.
- R7: For read commands 0x04 and 0x09, len + 1 bytes are clocked. Result byte i is (rx[i] << 1) | rx[i+1][7], so the first received bit is dropped.
- R8: A 0x04 or 0x09 request whose len is not 3 or 4 produces err and done together in one cycle. cs_n stays high and no clock is sent.
- R9: Every command outside the read set is a write, even with len = 0. A read with len = 0 sends only the command byte.
- R10: sclk never rises while cs_n is high. done pulses once per transaction, with cs_n high and busy low.
- R11: A start pulse while busy is ignored. The running transaction completes unchanged and produces only one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| cmd | input | 8 | Command byte for the request |
| len | input | LEN_W | Number of data bytes to write or read |
| tx_byte | input | 8 | Next write data byte |
| tx_take | output | 1 | Pulse when tx_byte has been loaded |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | End-of-transaction pulse |
| err | output | 1 | Length rejected for an identity/status read |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | Strobe for rd_data |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| dc | output | 1 | Data/command select, low for command |
| cs_n | output | 1 | Chip select, active low |

## Verification
The properties assume that the host pulses start only while busy is low and holds tx_byte steady between tx_take pulses. They also assume that the display device changes miso only after a rising sclk edge. The bench holds to these assumptions: it offers each data byte from an array indexed by the take count, and its device model updates miso one cycle after each rising edge it sees. The one exception is a deliberate start pulse issued in the middle of a transaction, which checks that such a request is ignored. Commands, lengths, payloads and reply streams are drawn from a seeded random generator. Directed cases cover rejected lengths, zero lengths and the dummy-bit reads.

// File: rtl/dbi_spi_pkg.sv
package dbi_spi_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} state_e;
    typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;

    localparam logic [7:0] CMD_MEM_WRITE = 8'h2C;
    localparam logic [7:0] CMD_IDENT     = 8'h04;
    localparam logic [7:0] CMD_STATUS    = 8'h09;

    function automatic logic is_read_cmd(input logic [7:0] c);
        case (c)
            8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
            8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
            8'h56, 8'h5F, 8'hA1, 8'hA8: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic logic has_dummy_bit(input logic [7:0] c);
        return (c == CMD_IDENT) || (c == CMD_STATUS);
    endfunction

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // clock cycles per half serial period, rounded up so the rate never exceeds the limit
    function automatic int half_div(input int clk_hz, input int sclk_hz);
        int h;
        h = (clk_hz + 2 * sclk_hz - 1) / (2 * sclk_hz);
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/dbi_sclk_gen.sv
module dbi_sclk_gen #(
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [HW-1:0] half_lim,
    output logic          sclk,
    output logic          ev_rise,
    output logic          ev_fall
);
    logic [HW-1:0] cnt;
    logic          ev;

    assign ev      = run && (cnt == half_lim - 1'b1);
    assign ev_rise = ev && !sclk;
    assign ev_fall = ev && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (ev) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dbi_rx_align.sv
module dbi_rx_align #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             skip_first,
    input  logic             sample,
    input  logic             miso,
    input  logic [LEN_W-1:0] want,
    output logic [7:0]       rx_byte,
    output logic             rx_valid
);
    logic             skip;
    logic [6:0]       sr;
    logic [2:0]       bcnt;
    logic [LEN_W-1:0] got;

    always_ff @(posedge clk) begin
        if (rst) begin
            skip     <= 1'b0;
            sr       <= '0;
            bcnt     <= '0;
            got      <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clear) begin
                skip <= skip_first;
                bcnt <= '0;
                got  <= '0;
            end else if (sample) begin
                if (skip) begin
                    skip <= 1'b0;
                end else begin
                    sr   <= {sr[5:0], miso};
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == 3'd7 && got < want) begin
                        rx_byte  <= {sr, miso};
                        rx_valid <= 1'b1;
                        got      <= got + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dbi_spi_master.sv
module dbi_spi_master
    import dbi_spi_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int MAX_HZ       = 25_000_000,
    parameter int CMD_LIMIT_HZ = 10_000_000,
    parameter int RD_LIMIT_HZ  = 2_000_000,
    parameter int LEN_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       cmd,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       tx_byte,
    output logic             tx_take,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             dc,
    output logic             cs_n
);
    localparam int FAST_HALF = half_div(CLK_HZ, MAX_HZ);
    localparam int CMD_HALF  = half_div(CLK_HZ, min_int(CMD_LIMIT_HZ, MAX_HZ));
    localparam int RD_HALF   = half_div(CLK_HZ, min_int(RD_LIMIT_HZ, MAX_HZ / 2));
    localparam int MAX_HALF  = (RD_HALF > CMD_HALF) ? RD_HALF : CMD_HALF;
    localparam int HW        = $clog2(MAX_HALF + 1);

    state_e           st;
    phase_e           ph;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W:0]   bytes_left;
    logic [2:0]       bit_idx;
    logic [7:0]       sr_tx;
    logic             rd_q, dummy_q, fast_q;
    logic [HW-1:0]    half_lim;
    logic             ev_rise, ev_fall, accept, rd_phase;

    assign accept   = (st == ST_IDLE) && start &&
                      !(has_dummy_bit(cmd) && !(len == LEN_W'(3) || len == LEN_W'(4)));
    assign rd_phase = (st == ST_SHIFT) && (ph == PH_RD);
    assign busy     = (st != ST_IDLE);
    assign mosi     = sr_tx[7];

    always_comb begin
        if (ph == PH_RD)               half_lim = HW'(RD_HALF);
        else if (ph == PH_WR && fast_q) half_lim = HW'(FAST_HALF);
        else                            half_lim = HW'(CMD_HALF);
    end

    dbi_sclk_gen #(.HW(HW)) u_sclk (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_SHIFT),
        .half_lim(half_lim),
        .sclk    (sclk),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    dbi_rx_align #(.LEN_W(LEN_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .skip_first(has_dummy_bit(cmd)),
        .sample    (ev_rise && rd_phase),
        .miso      (miso),
        .want      (len_q),
        .rx_byte   (rd_data),
        .rx_valid  (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ph         <= PH_CMD;
            len_q      <= '0;
            bytes_left <= '0;
            bit_idx    <= '0;
            sr_tx      <= '0;
            rd_q       <= 1'b0;
            dummy_q    <= 1'b0;
            fast_q     <= 1'b0;
            cs_n       <= 1'b1;
            dc         <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            tx_take    <= 1'b0;
        end else begin
            done    <= 1'b0;
            err     <= 1'b0;
            tx_take <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st      <= ST_SHIFT;
                        ph      <= PH_CMD;
                        len_q   <= len;
                        rd_q    <= is_read_cmd(cmd);
                        dummy_q <= has_dummy_bit(cmd);
                        fast_q  <= (cmd == CMD_MEM_WRITE);
                        sr_tx   <= cmd;
                        bit_idx <= '0;
                        cs_n    <= 1'b0;
                        dc      <= 1'b0;
                    end else if (start) begin
                        err  <= 1'b1;
                        done <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (ev_fall) begin
                        if (bit_idx != 3'd7) begin
                            bit_idx <= bit_idx + 1'b1;
                            sr_tx   <= {sr_tx[6:0], 1'b0};
                        end else begin
                            bit_idx <= '0;
                            if (ph == PH_CMD) begin
                                if (len_q == '0) begin
                                    st   <= ST_GAP;
                                    cs_n <= 1'b1;
                                    sr_tx <= '0;
                                end else if (rd_q) begin
                                    ph         <= PH_RD;
                                    sr_tx      <= '0;
                                    bytes_left <= {1'b0, len_q} + (LEN_W+1)'(dummy_q);
                                end else begin
                                    ph         <= PH_WR;
                                    dc         <= 1'b1;
                                    sr_tx      <= tx_byte;
                                    tx_take    <= 1'b1;
                                    bytes_left <= {1'b0, len_q};
                                end
                            end else if (bytes_left == (LEN_W+1)'(1)) begin
                                st    <= ST_GAP;
                                ph    <= PH_CMD;
                                cs_n  <= 1'b1;
                                dc    <= 1'b0;
                                sr_tx <= '0;
                            end else begin
                                bytes_left <= bytes_left - 1'b1;
                                if (ph == PH_WR) begin
                                    sr_tx   <= tx_byte;
                                    tx_take <= 1'b1;
                                end else begin
                                    sr_tx <= '0;
                                end
                            end
                        end
                    end
                end
                default: begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/dbi_spi_checks.sv
module dbi_spi_checks (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic dc,
    input logic done,
    input logic err,
    input logic busy,
    input logic rd_valid,
    input logic in_rd
);
    a_r10_clock_parked: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    a_r2_mosi_held_high_sclk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r6_read_lines_low: assert property (@(posedge clk) disable iff (rst)
        in_rd |-> (!mosi && !dc));

    a_r8_err_without_frame: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && cs_n));

    a_r10_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !busy));

    a_r6_valid_inside_frame: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !cs_n);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind dbi_spi_master dbi_spi_checks u_checks (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .mosi    (mosi),
    .dc      (dc),
    .done    (done),
    .err     (err),
    .busy    (busy),
    .rd_valid(rd_valid),
    .in_rd   (rd_phase)
);

// File: tb/dbi_spi_master_test.sv
module dbi_spi_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int H_CMD  = 5;
    localparam int H_FAST = 2;
    localparam int H_RD   = 25;
    localparam int LOGN   = 2048;

    logic       clk = 0, rst = 1, start = 0, miso = 0;
    logic [7:0] cmd = 0, len = 0;
    logic [7:0] tx_byte, rd_data;
    logic       tx_take, busy, done, err, rd_valid, sclk, mosi, dc, cs_n;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    dbi_spi_master uut (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .len(len),
        .tx_byte(tx_byte), .tx_take(tx_take), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .rd_valid(rd_valid), .sclk(sclk),
        .mosi(mosi), .miso(miso), .dc(dc), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // stimulus-owned
    logic [7:0]  wdata [64];
    logic [63:0] stream;
    int          tbase;

    // monitor-owned
    logic [7:0] lg_byte [LOGN];
    logic [1:0] lg_dc   [LOGN];
    int         lg_hw   [LOGN];
    logic [7:0] rbuf    [LOGN];
    int lg_n = 0, rn = 0, ttot = 0, dones = 0, errs = 0, stray = 0;
    int sl_cnt = 0, bpos = 0, hcnt = 0, cur_hw = 0;
    logic prev_sclk = 0, prev_cs = 1, first_pend = 0, dand = 1, dor = 0;
    logic [7:0] cur = 0;

    assign tx_byte = wdata[(ttot - tbase) & 63];

    always @(negedge clk) begin
        if (!cs_n && prev_cs) begin sl_cnt = 0; bpos = 0; end
        if (sclk && !prev_sclk) begin
            if (cs_n) stray++;
            if (bpos == 0) begin dand = 1; dor = 0; first_pend = 1; end
            cur = {cur[6:0], mosi};
            dand = dand & dc; dor = dor | dc;
            hcnt = 1;
            bpos++;
            if (bpos == 8) begin
                lg_byte[lg_n] = cur; lg_dc[lg_n] = {dand, dor}; lg_hw[lg_n] = cur_hw;
                lg_n++; bpos = 0;
            end
            sl_cnt++;
            if (sl_cnt >= 8 && sl_cnt - 8 < 64) miso = stream[sl_cnt - 8];
            else miso = 0;
        end else if (sclk) begin
            hcnt++;
        end
        if (!sclk && prev_sclk && first_pend) begin cur_hw = hcnt; first_pend = 0; end
        if (tx_take) ttot++;
        if (rd_valid) begin rbuf[rn] = rd_data; rn++; end
        if (done) dones++;
        if (err) errs++;
        prev_sclk = sclk; prev_cs = cs_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit b_is_read(input logic [7:0] c);
        logic [7:0] l [20] = '{8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
                               8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
                               8'h56, 8'h5F, 8'hA1, 8'hA8};
        for (int i = 0; i < 20; i++) if (l[i] == c) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] exp_rd(input int i, input bit dm);
        logic [7:0] v;
        for (int j = 0; j < 8; j++) v[7-j] = stream[8*i + int'(dm) + j];
        return v;
    endfunction

    task automatic xact(input logic [7:0] c, input int n, input bit intrude);
        int lb, rb, tb, db, eb, wait_c, exp_n, hw;
        bit rd, dm, rej;
        rd  = b_is_read(c);
        dm  = (c == 8'h04) || (c == 8'h09);
        rej = dm && !(n == 3 || n == 4);
        for (int i = 0; i < 64; i++) wdata[i] = 8'($urandom);
        stream = {$urandom, $urandom};
        @(negedge clk); #1;
        lb = lg_n; rb = rn; tb = ttot; db = dones; eb = errs; tbase = ttot;
        cmd = c; len = 8'(n); start = 1;
        @(negedge clk); start = 0;
        wait_c = 0;
        while (dones == db && wait_c < 20000) begin
            @(negedge clk); #1; wait_c++;
            if (intrude && wait_c == 30) begin cmd = 8'h0A; len = 1; start = 1; end
            if (intrude && wait_c == 31) start = 0;
        end
        repeat (4) @(negedge clk);
        #1;
        chk(dones - db == 1, "R10 one done", dones - db, 1);
        chk(cs_n == 1, "R10 cs high after", cs_n, 1);
        if (rej) begin
            chk(errs - eb == 1, "R8 err", errs - eb, 1);
            chk(lg_n == lb, "R8 no clock", lg_n - lb, 0);
            return;
        end
        chk(errs == eb, "R8 no err", errs - eb, 0);
        exp_n = 1 + (rd ? ((n == 0) ? 0 : n + int'(dm)) : n);
        chk(lg_n - lb == exp_n, rd ? "R7 byte count" : "R9 byte count", lg_n - lb, exp_n);
        chk(lg_byte[lb] == c, "R2 cmd byte", lg_byte[lb], c);
        chk(lg_dc[lb] == 2'b00, "R2 cmd dc low", lg_dc[lb], 0);
        chk(lg_hw[lb] == H_CMD, "R4 cmd rate", lg_hw[lb], H_CMD);
        for (int i = 1; i < exp_n && i < lg_n - lb + 1; i++) begin
            if (rd) begin
                chk(lg_byte[lb+i] == 0 && lg_dc[lb+i] == 2'b00, "R6 read lines low",
                    {lg_dc[lb+i], lg_byte[lb+i]}, 0);
                chk(lg_hw[lb+i] == H_RD, "R6 read rate", lg_hw[lb+i], H_RD);
            end else begin
                hw = (c == 8'h2C) ? H_FAST : H_CMD;
                chk(lg_byte[lb+i] == wdata[i-1], "R3 data byte", lg_byte[lb+i], wdata[i-1]);
                chk(lg_dc[lb+i] == 2'b11, "R3 dc high", lg_dc[lb+i], 3);
                chk(lg_hw[lb+i] == hw, (c == 8'h2C) ? "R5 pixel rate" : "R4 param rate",
                    lg_hw[lb+i], hw);
            end
        end
        chk(ttot - tb == (rd ? 0 : n), "R3 take count", ttot - tb, rd ? 0 : n);
        chk(rn - rb == (rd ? n : 0), "R9 read count", rn - rb, rd ? n : 0);
        if (rd) for (int i = 0; i < n && i < rn - rb; i++)
            chk(rbuf[rb+i] == exp_rd(i, dm), dm ? "R7 realigned byte" : "R6 read byte",
                rbuf[rb+i], exp_rd(i, dm));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
            summary();
        end
    end

    initial begin
        logic [7:0] c;
        int k, n;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 64; i++) wdata[i] = 0;
        stream = 0; tbase = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        chk(cs_n == 1 && sclk == 0 && mosi == 0 && dc == 0 && busy == 0 && done == 0,
            "R1 reset state", {cs_n, sclk, mosi, dc, busy, done}, 6'b100000);
        // directed corners
        xact(8'h04, 2, 0);   // R8
        xact(8'h09, 5, 0);   // R8
        xact(8'h04, 3, 0);   // R7
        xact(8'h09, 4, 0);   // R7
        xact(8'h0A, 1, 0);   // R6
        xact(8'h2E, 3, 0);   // R6
        xact(8'h0C, 0, 0);   // R9 read, len 0
        xact(8'h2C, 4, 0);   // R5
        xact(8'h2A, 4, 0);   // R4
        xact(8'h05, 0, 0);   // R9 write, len 0
        xact(8'h2B, 2, 1);   // R11 start while busy
        // random
        for (int t = 0; t < 36; t++) begin
            k = $urandom % 4;
            case (k)
                0: begin
                    c = 8'($urandom);
                    while (b_is_read(c) || c == 8'h2C) c = c + 8'd1;
                    n = $urandom % 6;
                end
                1: begin c = 8'h2C; n = $urandom % 7; end
                2: begin
                    c = 8'($urandom);
                    while (!b_is_read(c) || c == 8'h04 || c == 8'h09) c = c + 8'd1;
                    n = $urandom % 4;
                end
                default: begin
                    c = ($urandom % 2) ? 8'h04 : 8'h09;
                    n = ($urandom % 5 == 0) ? ($urandom % 6) : 3 + ($urandom % 2);
                end
            endcase
            xact(c, n, 0);
        end
        chk(stray == 0, "R10 no clock while deselected", stray, 0);
        summary();
    end
endmodule